// File: doc/BRIEF.md
# Time-Slot Shared-Memory Arbiter with External Host Port

This block places one single-port synchronous memory behind nine requesters: a set of internal cores (eight by default) and one external host. A slot pointer steps through the cores one per clock and wraps around. In each step the core that owns the slot gets the memory if it is requesting. Because of this, the access latency of every core is fixed and bounded. It does not depend on what the host is doing.

To the external host the block looks like an ordinary RAM. It has a select, a write-enable, an address, write data, read data and a wait line. The host inputs pass through a two-stage synchronizer, and one request is latched at a time. The latched request is served in the first slot whose owner is not requesting, and that can be any slot. A host request therefore never displaces a core. When the cores are quiet, the host can use as many slots per rotation as its handshake allows.

A core raises its request and holds it until its one-clock grant. Writes take effect at the end of the grant cycle. Read data arrives on a shared bus one clock after the grant, marked by a per-core valid strobe. The host raises select and waits for the wait line to drop. It then takes the read data, releases select, and waits for the wait line to rise before it starts the next access.

Top module: `hubmem_arbiter`

## Requirements
- R1: The slot pointer advances by one every clock and wraps from N_CORES-1 to 0. A core is granted only in its own slot, and only while its request is high. At most one grant is active at a time.
- R2: A grant lasts exactly one clock. The write address and data are sampled in that clock. For a read, `core_rdata` carries the word in the following clock, with `core_rvalid` bit i high for that one clock only.
- R3: A core that raises its request and holds it is granted within 8 clocks, whatever the host is doing.
- R4: The host is served only in a slot whose owning core has no request that clock. Any slot that goes unused may be taken, and a host access never coincides with a core grant.
- R5: The host inputs are synchronized through two register stages. A request is latched when the synchronized select is seen high, and no new request is accepted until select has been seen low again.
- R6: `host_wait` is 1 out of reset and while a host request is pending. It falls once the transfer has completed and rises again after the host releases select.
- R7: After a host read, `host_dout` holds the word that was read, registered. It is valid from the clock in which `host_wait` falls until select is released, and it is stable over that whole interval.
- R8: Host and core accesses to the same address complete in slot order. A core read after a host write returns the host's data, and a host read that is served after a core's write returns the core's data.
- R9: Out of reset, `core_gnt` and `core_rvalid` are all 0, `host_wait` is 1 and `host_dout` is 0.
- R10: While every core requests continuously, a pending host request is not served and `host_wait` stays 1. It completes once any core leaves its slot idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | N_CORES | Per-core request, held until granted |
| core_we | input | N_CORES | Per-core write enable (1 = write) |
| core_addr | input | N_CORES*AW | Per-core word address, core i at bits [i*AW +: AW] |
| core_wdata | input | N_CORES*DW | Per-core write data, core i at bits [i*DW +: DW] |
| core_gnt | output | N_CORES | One-clock grant in the core's own slot |
| core_rvalid | output | N_CORES | Read data valid for core i, one clock after its grant |
| core_rdata | output | DW | Shared read data bus |
| host_sel | input | 1 | Host select, active high, asynchronous |
| host_wr | input | 1 | Host write enable (1 = write) |
| host_addr | input | AW | Host word address |
| host_din | input | DW | Host write data |
| host_dout | output | DW | Host read data, registered and held |
| host_wait | output | 1 | Stall to host, 1 until the access completes |

## Verification
If the slot pointer is wrong, a grant appears in a slot that belongs to another core, or no grant appears at all. A requesting core then waits more than eight clocks, which shows within a single rotation. If the host arbitration is wrong, the host either takes a slot whose owner is requesting, which shows as a missing or late core grant, or it is never granted, which leaves `host_wait` stuck high. A wrong host state shows at the ports as read data that changes while `host_wait` is low, or as `host_wait` that does not return high after select is released. A mux fault shows as a wrong word one clock after a grant, or at the fall of `host_wait`.

// File: rtl/hubmem_pkg.sv
package hubmem_pkg;
  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_PEND  = 2'd1,
    HS_RDLAT = 2'd2,
    HS_HOLD  = 2'd3
  } host_state_e;
endpackage

// File: rtl/hubmem_slot_ring.sv
module hubmem_slot_ring #(
  parameter int N_CORES = 8,
  localparam int SW = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] slot_q
);
  localparam logic [SW-1:0] LAST = SW'(N_CORES - 1);

  always_ff @(posedge clk) begin
    if (rst)                 slot_q <= '0;
    else if (slot_q == LAST) slot_q <= '0;
    else                     slot_q <= slot_q + 1'b1;
  end

  // R1: pointer steps by one and wraps at the last core
  a_r1_slot_step: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> slot_q == (($past(slot_q) == LAST) ? '0 : $past(slot_q) + 1'b1));
endmodule

// File: rtl/hubmem_ram.sv
module hubmem_ram #(
  parameter int AW = 11,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/hubmem_host_port.sv
module hubmem_host_port
  import hubmem_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_din,
  input  logic          slot_busy,
  input  logic [DW-1:0] ram_rdata,
  output logic          host_go,
  output logic          hp_we,
  output logic [AW-1:0] hp_addr,
  output logic [DW-1:0] hp_wdata,
  output logic          host_wait,
  output logic [DW-1:0] host_dout
);
  logic [1:0]    sel_sy;
  logic [1:0]    wr_sy;
  logic [AW-1:0] addr_s1, addr_s2;
  logic [DW-1:0] din_s1, din_s2;
  host_state_e   st, nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_sy  <= '0;
      wr_sy   <= '0;
      addr_s1 <= '0;
      addr_s2 <= '0;
      din_s1  <= '0;
      din_s2  <= '0;
    end else begin
      sel_sy  <= {sel_sy[0], host_sel};
      wr_sy   <= {wr_sy[0], host_wr};
      addr_s1 <= host_addr;
      addr_s2 <= addr_s1;
      din_s1  <= host_din;
      din_s2  <= din_s1;
    end
  end

  assign host_go = (st == HS_PEND) && !slot_busy;

  always_comb begin
    nxt = st;
    unique case (st)
      HS_IDLE:  if (sel_sy[1]) nxt = HS_PEND;
      HS_PEND:  if (host_go)   nxt = hp_we ? HS_HOLD : HS_RDLAT;
      HS_RDLAT: nxt = HS_HOLD;
      HS_HOLD:  if (!sel_sy[1]) nxt = HS_IDLE;
      default:  nxt = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= HS_IDLE;
      host_wait <= 1'b1;
      host_dout <= '0;
      hp_we     <= 1'b0;
      hp_addr   <= '0;
      hp_wdata  <= '0;
    end else begin
      st        <= nxt;
      host_wait <= (nxt != HS_HOLD);
      if (st == HS_IDLE && sel_sy[1]) begin
        hp_we    <= wr_sy[1];
        hp_addr  <= addr_s2;
        hp_wdata <= din_s2;
      end
      if (st == HS_RDLAT) host_dout <= ram_rdata;
    end
  end

  // R5: a served request is not served again in the next clock
  a_r5_single_service: assert property (@(posedge clk) disable iff (rst)
    host_go |=> !host_go);
  // R6: wait stays high while the request is pending
  a_r6_wait_pending: assert property (@(posedge clk) disable iff (rst)
    (st == HS_PEND) |-> host_wait);
  // R7: read data is held while wait stays low
  a_r7_dout_hold: assert property (@(posedge clk) disable iff (rst)
    (!host_wait && $past(!host_wait)) |-> $stable(host_dout));
endmodule

// File: rtl/hubmem_arbiter.sv
module hubmem_arbiter #(
  parameter int N_CORES = 8,
  parameter int AW = 11,
  parameter int DW = 32,
  localparam int SW = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int CW = SW + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_CORES-1:0]    core_req,
  input  logic [N_CORES-1:0]    core_we,
  input  logic [N_CORES*AW-1:0] core_addr,
  input  logic [N_CORES*DW-1:0] core_wdata,
  output logic [N_CORES-1:0]    core_gnt,
  output logic [N_CORES-1:0]    core_rvalid,
  output logic [DW-1:0]         core_rdata,
  input  logic                  host_sel,
  input  logic                  host_wr,
  input  logic [AW-1:0]         host_addr,
  input  logic [DW-1:0]         host_din,
  output logic [DW-1:0]         host_dout,
  output logic                  host_wait
);
  logic [SW-1:0] slot_q;
  logic          host_go, hp_we;
  logic [AW-1:0] hp_addr;
  logic [DW-1:0] hp_wdata;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wd, ram_rd;
  logic          slot_busy;

  hubmem_slot_ring #(.N_CORES(N_CORES)) u_ring (
    .clk(clk), .rst(rst), .slot_q(slot_q)
  );

  for (genvar i = 0; i < N_CORES; i++) begin : g_gnt
    assign core_gnt[i] = core_req[i] && (slot_q == SW'(i));
  end

  always_comb begin
    slot_busy = 1'b0;
    for (int i = 0; i < N_CORES; i++)
      if (slot_q == SW'(i)) slot_busy = core_req[i];
  end

  hubmem_host_port #(.AW(AW), .DW(DW)) u_host (
    .clk(clk), .rst(rst),
    .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr), .host_din(host_din),
    .slot_busy(slot_busy), .ram_rdata(ram_rd),
    .host_go(host_go), .hp_we(hp_we), .hp_addr(hp_addr), .hp_wdata(hp_wdata),
    .host_wait(host_wait), .host_dout(host_dout)
  );

  always_comb begin
    ram_en   = host_go;
    ram_we   = hp_we;
    ram_addr = hp_addr;
    ram_wd   = hp_wdata;
    for (int i = 0; i < N_CORES; i++) begin
      if (core_gnt[i]) begin
        ram_en   = 1'b1;
        ram_we   = core_we[i];
        ram_addr = core_addr[i*AW +: AW];
        ram_wd   = core_wdata[i*DW +: DW];
      end
    end
  end

  hubmem_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wd), .rdata(ram_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) core_rvalid <= '0;
    else     core_rvalid <= core_gnt & ~core_we;
  end
  assign core_rdata = ram_rd;

  // R1: a grant belongs only to the core that owns the current slot
  a_r1_gnt_owner: assert property (@(posedge clk) disable iff (rst)
    (|core_gnt) |-> (core_gnt == (N_CORES'(1) << slot_q)));
  // R4: host and core never use the memory in the same clock
  a_r4_no_displace: assert property (@(posedge clk) disable iff (rst)
    $onehot0({host_go, core_gnt}));
  // R2: at most one read strobe per clock
  a_r2_rvalid_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(core_rvalid));

  for (genvar i = 0; i < N_CORES; i++) begin : g_chk
    logic [CW-1:0] wait_cnt;
    always_ff @(posedge clk) begin
      if (rst || !core_req[i] || core_gnt[i]) wait_cnt <= '0;
      else                                    wait_cnt <= wait_cnt + 1'b1;
    end
    // R3: a held request is granted before a full rotation has passed
    a_r3_bounded_wait: assert property (@(posedge clk) disable iff (rst)
      wait_cnt < CW'(N_CORES));
    // R2: a grant never lasts two clocks
    a_r2_gnt_one_clock: assert property (@(posedge clk) disable iff (rst)
      core_gnt[i] |=> !core_gnt[i]);
  end
endmodule

// File: tb/tb_hubmem_arbiter.sv
`timescale 1ns/1ps
module tb_hubmem_arbiter;
  localparam int N  = 8;
  localparam int AW = 11;
  localparam int DW = 32;
  localparam int HOST = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    core_req = '0, core_we = '0;
  logic [N*AW-1:0] core_addr = '0;
  logic [N*DW-1:0] core_wdata = '0;
  logic [N-1:0]    core_gnt, core_rvalid;
  logic [DW-1:0]   core_rdata;
  logic            host_sel = 1'b0, host_wr = 1'b0;
  logic [AW-1:0]   host_addr = '0;
  logic [DW-1:0]   host_din = '0, host_dout;
  logic            host_wait;

  always #2.5 clk = ~clk;

  hubmem_arbiter #(.N_CORES(N), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .core_req(core_req), .core_we(core_we),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_gnt(core_gnt),
    .core_rvalid(core_rvalid), .core_rdata(core_rdata), .host_sel(host_sel),
    .host_wr(host_wr), .host_addr(host_addr), .host_din(host_din),
    .host_dout(host_dout), .host_wait(host_wait)
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] model [1<<AW];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic core_op(input int c, input bit we, input logic [AW-1:0] a,
                         input logic [DW-1:0] d);
    int cyc;
    logic [DW-1:0] exp;
    exp = model[a];
    core_we[c] = we;
    core_addr[c*AW +: AW] = a;
    core_wdata[c*DW +: DW] = d;
    core_req[c] = 1'b1;
    #1;
    cyc = 1;
    while (!core_gnt[c] && cyc < 40) begin
      @(negedge clk); #1; cyc++;
    end
    check(cyc <= 8, "R3", "clocks until core grant", cyc, 8);
    @(negedge clk);
    check(!core_gnt[c], "R2", "grant lasts one clock", core_gnt[c], 0);
    if (!we) begin
      check(core_rvalid[c], "R2", "read valid one clock after grant", core_rvalid[c], 1);
      check(core_rdata === exp, "R8", "core read data", core_rdata, exp);
    end else begin
      check(!core_rvalid[c], "R2", "no valid strobe on write", core_rvalid[c], 0);
      model[a] = d;
    end
    core_req[c] = 1'b0;
  endtask

  task automatic host_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int cyc;
    logic [DW-1:0] exp;
    exp = model[a];
    host_wr = we; host_addr = a; host_din = d; host_sel = 1'b1;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (host_wait && cyc < 200);
    check(!host_wait, "R6", "wait released after transfer", host_wait, 0);
    if (!we) begin
      check(host_dout === exp, "R7", "host read data", host_dout, exp);
      for (int k = 0; k < 3; k++) @(negedge clk);
      check(host_dout === exp && !host_wait, "R7", "read data held until release", host_dout, exp);
    end else begin
      model[a] = d;
    end
    host_sel = 1'b0;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!host_wait && cyc < 20);
    check(host_wait, "R6", "wait rises after select release", host_wait, 1);
  endtask

  // {requester(4), we(1), addr(11), data(32)}; requester 8 is the host
  localparam int VN = 12;
  localparam logic [47:0] VEC [VN] = '{
    {4'd8, 1'b1, 11'h010, 32'hDEADBEEF},
    {4'd3, 1'b0, 11'h010, 32'h0},
    {4'd5, 1'b1, 11'h123, 32'h12345678},
    {4'd8, 1'b0, 11'h123, 32'h0},
    {4'd0, 1'b1, 11'h7FF, 32'hA5A50001},
    {4'd7, 1'b0, 11'h7FF, 32'h0},
    {4'd8, 1'b1, 11'h7FF, 32'h0BADF00D},
    {4'd1, 1'b0, 11'h7FF, 32'h0},
    {4'd6, 1'b1, 11'h000, 32'hFFFFFFFF},
    {4'd8, 1'b0, 11'h000, 32'h0},
    {4'd4, 1'b0, 11'h010, 32'h0},
    {4'd8, 1'b0, 11'h010, 32'h0}
  };

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cyc;
    logic [DW-1:0] got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(core_gnt == '0, "R9", "no grant after reset", core_gnt, 0);
    check(core_rvalid == '0, "R9", "no valid after reset", core_rvalid, 0);
    check(host_wait, "R9", "wait high after reset", host_wait, 1);
    check(host_dout == '0, "R9", "host data zero after reset", host_dout, 0);

    // R1 R2 R8: table walk
    for (int v = 0; v < VN; v++) begin
      if (int'(VEC[v][47:44]) == HOST) host_op(VEC[v][43], VEC[v][42:32], VEC[v][31:0]);
      else core_op(int'(VEC[v][47:44]), VEC[v][43], VEC[v][42:32], VEC[v][31:0]);
    end

    // R1: each core is granted in a distinct slot of one rotation
    core_req = '1; core_we = '0; core_addr = '0;
    got = '0;
    for (int k = 0; k < N; k++) begin
      @(negedge clk); #1;
      check($countones(core_gnt) == 1, "R1", "exactly one grant per clock", core_gnt, 1);
      got[N-1:0] = got[N-1:0] | core_gnt;
    end
    check(got[N-1:0] == '1, "R1", "all cores granted in one rotation", got, 32'hFF);

    // R10 R4: host starved while all cores request
    host_wr = 1'b1; host_addr = 11'h055; host_din = 32'h55AA55AA; host_sel = 1'b1;
    repeat (30) @(negedge clk);
    check(host_wait, "R10", "host stalls while every slot is used", host_wait, 1);
    core_req[5] = 1'b0;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (host_wait && cyc < 40);
    check(!host_wait && cyc <= 16, "R4", "host takes the freed slot", cyc, 16);
    model[11'h055] = 32'h55AA55AA;
    host_sel = 1'b0;
    repeat (6) @(negedge clk);
    core_req = '0;
    @(negedge clk);
    core_op(2, 1'b0, 11'h055, 32'h0);

    // R8: host read pending while core 2 writes; all other slots busy
    core_req = '1; core_we = '0; core_addr = '0;
    core_we[2] = 1'b1; core_addr[2*AW +: AW] = 11'h0AB; core_wdata[2*DW +: DW] = 32'hC0DE0002;
    host_wr = 1'b0; host_addr = 11'h0AB; host_sel = 1'b1;
    #1;
    while (!core_gnt[2]) begin @(negedge clk); #1; end
    @(negedge clk);
    core_req[2] = 1'b0;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (host_wait && cyc < 40);
    check(host_dout == 32'hC0DE0002, "R8", "host read after core write in slot order",
          host_dout, 32'hC0DE0002);
    model[11'h0AB] = 32'hC0DE0002;
    host_sel = 1'b0;
    repeat (6) @(negedge clk);
    core_req = '0; core_we = '0;
    @(negedge clk);

    // R3 R5: cores keep their latency while the host runs back-to-back reads
    fork
      begin
        host_op(1'b0, 11'h010, 32'h0);
        host_op(1'b0, 11'h7FF, 32'h0);
        host_op(1'b0, 11'h0AB, 32'h0);
      end
      begin
        for (int k = 0; k < N; k++) begin
          core_op(k, 1'b0, 11'h123, 32'h0);
          @(negedge clk);
        end
      end
    join

    // R5: select held high after completion does not start a new access
    host_wr = 1'b1; host_addr = 11'h200; host_din = 32'h11112222; host_sel = 1'b1;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (host_wait && cyc < 40);
    model[11'h200] = 32'h11112222;
    host_addr = 11'h201; host_din = 32'h33334444;
    repeat (10) @(negedge clk);
    check(!host_wait, "R5", "no second access while select stays high", host_wait, 0);
    host_sel = 1'b0;
    repeat (6) @(negedge clk);
    model[11'h201] = 32'h0;
    core_op(3, 1'b1, 11'h201, 32'h0);
    core_op(6, 1'b0, 11'h200, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule